// File: doc/BRIEF.md
# Split-Space Memory Access Router

This block steers every memory access from a small 8-bit controller core to the right target. Program fetches take a 16-bit address. They go either to an on-chip program store or to an off-chip program interface. The choice depends on an external-access strap, which is captured once after reset. Data accesses take an 8-bit address, a direct/indirect mode flag and a write strobe. They reach a 256-byte RAM held inside the block, or a bus toward the special-function registers.

The upper half of the data address range, 80h to FFh, is backed twice. A direct-mode access there reaches the register bus. An indirect-mode access at the same address reaches the upper 128 RAM bytes. The block also keeps the stack pointer. Push and pop always resolve like indirect accesses, so the stack may grow into the upper RAM half.

A parameter mask marks which register addresses exist. A direct access to any other address raises a flag, never strobes the register bus and reads back as 00h. This keeps reads of such addresses deterministic.

Top module: `mrt_router`

## Requirements
- R1: During reset and in the first cycle after it, the stack pointer is 07h, no read result is valid and no register-bus strobe is asserted.
- R2: When the captured strap is low, every fetch raises the external program request and never the internal one.
- R3: When the captured strap is high, fetches below 2000h raise the internal program request and fetches at 2000h or above raise the external one. The fetch address is passed through unchanged in the same cycle.
- R4: The strap is captured at the first rising clock edge after reset is released. Later changes of the strap pin do not affect fetch steering until the next reset.
- R5: Data accesses to 00h–7Fh reach RAM in either mode and never strobe the register bus.
- R6: A direct access to an implemented address of 80h–FFh strobes the register bus in the same cycle, with address, write flag and write data. For a read, the value on the register read input in that cycle is returned one cycle later.
- R7: An indirect access to 80h–FFh reaches the upper RAM half, separate from the register at the same address, and never strobes the register bus.
- R8: A read returns its data one cycle after the request, with the valid flag high for that cycle. A RAM write takes effect at the clock edge of its strobe, so a read in the next cycle returns the new value.
- R9: A push first increments the stack pointer (mod 256) and then writes RAM at the new value. A pop reads RAM at the current pointer, with the data returned one cycle later, and then decrements it (mod 256).
- R10: A push takes precedence over a pop, and a push or pop takes precedence over a data access requested in the same cycle. The losing requests have no effect.
- R11: In the default configuration, a register address is implemented when its low three bits are 000 or it lies in 81h–87h. A direct access to any other address of 80h–FFh raises the unimplemented flag, gives no register-bus strobe and reads back 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_strap_i | input | 1 | External-access strap: low forces all fetches off-chip |
| fetch_req_i | input | 1 | Program fetch request |
| fetch_addr_i | input | 16 | Program fetch address |
| pm_int_req_o | output | 1 | Request to the internal program store |
| pm_ext_req_o | output | 1 | Request to the external program interface |
| pm_addr_o | output | 16 | Fetch address toward either program target |
| d_req_i | input | 1 | Data access request |
| d_indirect_i | input | 1 | 1 = indirect mode, 0 = direct mode |
| d_we_i | input | 1 | 1 = write, 0 = read |
| d_addr_i | input | 8 | Data address |
| d_wdata_i | input | 8 | Write data for data accesses and pushes |
| push_i | input | 1 | Stack push request |
| pop_i | input | 1 | Stack pop request |
| d_rvalid_o | output | 1 | Read data valid (one cycle after a read or pop) |
| d_rdata_o | output | 8 | Read data |
| sp_o | output | 8 | Current stack pointer |
| sfr_req_o | output | 1 | Register-bus strobe |
| sfr_we_o | output | 1 | Register-bus write flag |
| sfr_addr_o | output | 8 | Register-bus address |
| sfr_wdata_o | output | 8 | Register-bus write data |
| sfr_rdata_i | input | 8 | Register-bus read data, sampled in the strobe cycle |
| sfr_unimpl_o | output | 1 | Direct access to an unimplemented register address |

## Verification
Fetch steering, the register-bus strobe and the unimplemented flag are combinational. The bench checks them 2 ns after it drives the inputs on the falling edge, within the same cycle. Read data, the valid flag and the updated stack pointer appear one register stage later. They are checked 1 ns after the next rising edge, before the following stimulus is driven. The strap capture takes one edge after reset release. The bench toggles the pin only after that edge and checks fetches taken both before and after it.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    typedef enum logic [1:0] {
        RSRC_NONE = 2'd0,
        RSRC_RAM  = 2'd1,
        RSRC_SFR  = 2'd2,
        RSRC_ZERO = 2'd3
    } rsrc_e;

    // Default implemented-register set for 80h..FFh, bit i <-> address 80h+i
    function automatic logic [127:0] default_sfr_mask();
        logic [127:0] m;
        for (int i = 0; i < 128; i++) begin
            m[i] = (i[2:0] == 3'd0) || (i >= 1 && i <= 7);
        end
        return m;
    endfunction

endpackage

// File: rtl/mrt_fetch_steer.sv
module mrt_fetch_steer #(
    parameter int          PA_W      = 16,
    parameter logic [15:0] INT_LIMIT = 16'h2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_i,
    input  logic            req_i,
    input  logic [PA_W-1:0] addr_i,
    output logic            int_req_o,
    output logic            ext_req_o,
    output logic [PA_W-1:0] addr_o
);
    typedef struct packed {
        logic ea;
        logic done;
    } fs_t;

    fs_t fs_d, fs_q;
    logic ea_now;

    always_comb begin
        fs_d = fs_q;
        if (!fs_q.done) begin
            fs_d.ea   = strap_i;
            fs_d.done = 1'b1;
        end
        ea_now    = fs_q.done ? fs_q.ea : strap_i;
        int_req_o = req_i && ea_now && (addr_i < PA_W'(INT_LIMIT));
        ext_req_o = req_i && !(ea_now && (addr_i < PA_W'(INT_LIMIT)));
        addr_o    = addr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    p_strap_low_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_q.done && !fs_q.ea && req_i) |-> (ext_req_o && !int_req_o));
    p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |-> ($countones({int_req_o, ext_req_o}) == 1));
    p_strap_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fs_q.done |=> $stable(fs_q.ea));

endmodule

// File: rtl/mrt_sfr_decode.sv
module mrt_sfr_decode #(
    parameter int                      D_AW = 8,
    parameter logic [2**(D_AW-1)-1:0] IMPL = '1
) (
    input  logic [D_AW-1:0] addr_i,
    output logic            impl_o
);
    localparam int HALF = 2**(D_AW-1);
    logic [HALF-1:0] hit;

    for (genvar g = 0; g < HALF; g++) begin : g_hit
        assign hit[g] = IMPL[g] && (addr_i[D_AW-2:0] == (D_AW-1)'(g));
    end

    assign impl_o = |hit;

endmodule

// File: rtl/mrt_ram.sv
module mrt_ram #(
    parameter int D_AW = 8,
    parameter int D_W  = 8
) (
    input  logic            clk,
    input  logic            we_i,
    input  logic            re_i,
    input  logic [D_AW-1:0] addr_i,
    input  logic [D_W-1:0]  wdata_i,
    output logic [D_W-1:0]  rdata_o
);
    localparam int DEPTH = 2**D_AW;
    logic [D_W-1:0] mem [DEPTH];
    logic [D_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) mem[addr_i] <= wdata_i;
        if (re_i) rdata_q <= mem[addr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/mrt_router.sv
module mrt_router #(
    parameter int          PA_W      = 16,
    parameter logic [15:0] INT_LIMIT = 16'h2000,
    parameter int          D_AW      = 8,
    parameter int          D_W       = 8,
    parameter logic [7:0]  SP_RESET  = 8'h07,
    parameter logic [127:0] SFR_IMPL = mrt_pkg::default_sfr_mask()
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_strap_i,
    input  logic            fetch_req_i,
    input  logic [PA_W-1:0] fetch_addr_i,
    output logic            pm_int_req_o,
    output logic            pm_ext_req_o,
    output logic [PA_W-1:0] pm_addr_o,
    input  logic            d_req_i,
    input  logic            d_indirect_i,
    input  logic            d_we_i,
    input  logic [D_AW-1:0] d_addr_i,
    input  logic [D_W-1:0]  d_wdata_i,
    input  logic            push_i,
    input  logic            pop_i,
    output logic            d_rvalid_o,
    output logic [D_W-1:0]  d_rdata_o,
    output logic [D_AW-1:0] sp_o,
    output logic            sfr_req_o,
    output logic            sfr_we_o,
    output logic [D_AW-1:0] sfr_addr_o,
    output logic [D_W-1:0]  sfr_wdata_o,
    input  logic [D_W-1:0]  sfr_rdata_i,
    output logic            sfr_unimpl_o
);
    import mrt_pkg::*;

    localparam int HALF = 2**(D_AW-1);

    typedef struct packed {
        logic [D_AW-1:0] sp;
        rsrc_e           rsrc;
        logic [D_W-1:0]  sfr_data;
    } st_t;

    st_t st_d, st_q;

    logic            ram_we, ram_re;
    logic [D_AW-1:0] ram_addr;
    logic [D_W-1:0]  ram_rdata;
    logic            sfr_impl;
    logic            to_sfr;

    mrt_fetch_steer #(.PA_W(PA_W), .INT_LIMIT(INT_LIMIT)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_i   (ext_strap_i),
        .req_i     (fetch_req_i),
        .addr_i    (fetch_addr_i),
        .int_req_o (pm_int_req_o),
        .ext_req_o (pm_ext_req_o),
        .addr_o    (pm_addr_o)
    );

    mrt_sfr_decode #(.D_AW(D_AW), .IMPL(SFR_IMPL[HALF-1:0])) u_dec (
        .addr_i (d_addr_i),
        .impl_o (sfr_impl)
    );

    mrt_ram #(.D_AW(D_AW), .D_W(D_W)) u_ram (
        .clk     (clk),
        .we_i    (ram_we),
        .re_i    (ram_re),
        .addr_i  (ram_addr),
        .wdata_i (d_wdata_i),
        .rdata_o (ram_rdata)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rsrc    = RSRC_NONE;
        ram_we       = 1'b0;
        ram_re       = 1'b0;
        ram_addr     = d_addr_i;
        sfr_req_o    = 1'b0;
        sfr_unimpl_o = 1'b0;
        to_sfr       = d_addr_i[D_AW-1] && !d_indirect_i;

        if (push_i) begin
            st_d.sp  = st_q.sp + 1'b1;
            ram_addr = st_q.sp + 1'b1;
            ram_we   = 1'b1;
        end else if (pop_i) begin
            ram_addr  = st_q.sp;
            ram_re    = 1'b1;
            st_d.sp   = st_q.sp - 1'b1;
            st_d.rsrc = RSRC_RAM;
        end else if (d_req_i) begin
            if (to_sfr) begin
                if (sfr_impl) begin
                    sfr_req_o = 1'b1;
                    if (!d_we_i) begin
                        st_d.rsrc     = RSRC_SFR;
                        st_d.sfr_data = sfr_rdata_i;
                    end
                end else begin
                    sfr_unimpl_o = 1'b1;
                    if (!d_we_i) st_d.rsrc = RSRC_ZERO;
                end
            end else begin
                ram_we = d_we_i;
                ram_re = !d_we_i;
                if (!d_we_i) st_d.rsrc = RSRC_RAM;
            end
        end

        sfr_we_o    = sfr_req_o && d_we_i;
        sfr_addr_o  = d_addr_i;
        sfr_wdata_o = d_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sp       <= SP_RESET[D_AW-1:0];
            st_q.rsrc     <= RSRC_NONE;
            st_q.sfr_data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.rsrc)
            RSRC_RAM: d_rdata_o = ram_rdata;
            RSRC_SFR: d_rdata_o = st_q.sfr_data;
            default:  d_rdata_o = '0;
        endcase
    end

    assign d_rvalid_o = (st_q.rsrc != RSRC_NONE);
    assign sp_o       = st_q.sp;

    p_low_no_sfr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req_i && !d_addr_i[D_AW-1]) |-> !sfr_req_o);
    p_direct_hi_sfr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req_i && !d_indirect_i && d_addr_i[D_AW-1] && !push_i && !pop_i && !sfr_unimpl_o)
        |-> sfr_req_o);
    p_indirect_no_sfr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req_i && d_indirect_i) |-> !sfr_req_o);
    p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req_i && !d_we_i && !push_i) |=> d_rvalid_o);
    p_push_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (sp_o == $past(sp_o) + 1'b1));
    p_pop_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (sp_o == $past(sp_o) - 1'b1));
    p_stack_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i || pop_i) |-> (!sfr_req_o && !sfr_unimpl_o));
    p_unimpl_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_unimpl_o && !d_we_i) |=> (d_rvalid_o && d_rdata_o == '0));

endmodule

// File: tb/sim_mrt_router.sv
module sim_mrt_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_strap_i = 1'b0;
    logic        fetch_req_i = 1'b0;
    logic [15:0] fetch_addr_i = '0;
    logic        pm_int_req_o, pm_ext_req_o;
    logic [15:0] pm_addr_o;
    logic        d_req_i = 1'b0, d_indirect_i = 1'b0, d_we_i = 1'b0;
    logic [7:0]  d_addr_i = '0, d_wdata_i = '0;
    logic        push_i = 1'b0, pop_i = 1'b0;
    logic        d_rvalid_o;
    logic [7:0]  d_rdata_o, sp_o;
    logic        sfr_req_o, sfr_we_o, sfr_unimpl_o;
    logic [7:0]  sfr_addr_o, sfr_wdata_o, sfr_rdata_i;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] m_mem [256];
    bit         m_known [256];
    logic [7:0] m_sp;
    logic       m_ea;

    always #5ns clk = ~clk;
    assign sfr_rdata_i = sfr_addr_o ^ 8'hA5;

    mrt_router u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit impl(input logic [7:0] a);
        return (a[2:0] == 3'd0) || (a >= 8'h81 && a <= 8'h87);
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic clear_inputs();
        fetch_req_i = 0; d_req_i = 0; push_i = 0; pop_i = 0;
        d_we_i = 0; d_indirect_i = 0;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        clear_inputs();
        rst_n = 0; ext_strap_i = strap;
        repeat (2) @(negedge clk);
        chk(sp_o == 8'h07, "R1 sp in reset", sp_o, 8'h07);
        chk(!d_rvalid_o && !sfr_req_o, "R1 quiet in reset", {d_rvalid_o, sfr_req_o}, 0);
        rst_n = 1;
        m_sp = 8'h07; m_ea = strap;
        @(posedge clk); #1;
        chk(sp_o == 8'h07 && !d_rvalid_o, "R1 after release", {d_rvalid_o, sp_o}, 8'h07);
    endtask

    task automatic fetch(input logic [15:0] a, input string tag);
        bit ei;
        @(negedge clk);
        clear_inputs();
        fetch_req_i = 1; fetch_addr_i = a;
        #2;
        ei = m_ea && (a < 16'h2000);
        chk(pm_int_req_o == ei && pm_ext_req_o == !ei, tag, {pm_int_req_o, pm_ext_req_o}, {ei, !ei});
        chk(pm_addr_o == a, "R3 fetch address", pm_addr_o, a);
    endtask

    task automatic access(input bit psh, input bit pp, input bit rq, input bit ind,
                          input bit we, input logic [7:0] a, input logic [7:0] wd);
        bit         exp_rv = 0, exp_known = 0, to_sfr, im;
        logic [7:0] exp_d = '0;
        @(negedge clk);
        clear_inputs();
        push_i = psh; pop_i = pp; d_req_i = rq; d_indirect_i = ind;
        d_we_i = we; d_addr_i = a; d_wdata_i = wd;
        #2;
        to_sfr = a[7] && !ind;
        im = impl(a);
        if (psh) begin
            chk(!sfr_req_o && !sfr_unimpl_o, "R10 push hides data access", {sfr_req_o, sfr_unimpl_o}, 0);
            m_sp = m_sp + 1; m_mem[m_sp] = wd; m_known[m_sp] = 1;
        end else if (pp) begin
            chk(!sfr_req_o, "R10 pop hides data access", sfr_req_o, 0);
            exp_rv = 1; exp_known = m_known[m_sp]; exp_d = m_mem[m_sp];
            m_sp = m_sp - 1;
        end else if (rq) begin
            if (!a[7]) chk(!sfr_req_o, "R5 low address no strobe", sfr_req_o, 0);
            else if (ind) chk(!sfr_req_o && !sfr_unimpl_o, "R7 indirect no strobe", sfr_req_o, 0);
            else if (im) begin
                chk(sfr_req_o && sfr_we_o == we && sfr_addr_o == a, "R6 strobe",
                    {sfr_req_o, sfr_we_o, sfr_addr_o}, {1'b1, we, a});
                if (we) chk(sfr_wdata_o == wd, "R6 write data", sfr_wdata_o, wd);
            end else
                chk(sfr_unimpl_o && !sfr_req_o, "R11 unimpl flag", {sfr_unimpl_o, sfr_req_o}, 2'b10);
            if (we) begin
                if (!to_sfr) begin m_mem[a] = wd; m_known[a] = 1; end
            end else begin
                exp_rv = 1;
                if (to_sfr) begin exp_known = 1; exp_d = im ? (a ^ 8'hA5) : 8'h00; end
                else begin exp_known = m_known[a]; exp_d = m_mem[a]; end
            end
        end
        @(posedge clk); #1;
        chk(d_rvalid_o == exp_rv, "R8 valid flag", d_rvalid_o, exp_rv);
        if (exp_rv && exp_known) chk(d_rdata_o == exp_d, "R8 R9 read data", d_rdata_o, exp_d);
        chk(sp_o == m_sp, "R9 stack pointer", sp_o, m_sp);
    endtask

    initial begin
        #2ms;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) m_known[i] = 0;

        do_reset(1'b0);
        fetch(16'h0000, "R2 strap low");
        fetch(16'h1FFF, "R2 strap low");
        ext_strap_i = 1'b1;
        fetch(16'h0100, "R4 strap change ignored");

        do_reset(1'b1);
        fetch(16'h1FFF, "R3 internal top");
        fetch(16'h2000, "R3 external base");
        ext_strap_i = 1'b0;
        fetch(16'h0004, "R4 strap change ignored");

        access(0, 0, 1, 1, 1, 8'hA0, 8'h3C);
        access(0, 0, 1, 0, 0, 8'hA0, 8'h00);
        access(0, 0, 1, 1, 0, 8'hA0, 8'h00);
        access(0, 0, 1, 0, 1, 8'h20, 8'h11);
        access(0, 0, 1, 1, 0, 8'h20, 8'h00);
        access(0, 0, 1, 0, 1, 8'h90, 8'h77);
        access(0, 0, 1, 0, 0, 8'h89, 8'h00);
        access(0, 0, 1, 0, 1, 8'hFF, 8'h55);
        access(1, 1, 1, 0, 0, 8'h90, 8'h9A);
        access(0, 1, 1, 0, 0, 8'h88, 8'h00);
        for (int i = 0; i < 250; i++) access(1, 0, 0, 0, 0, 8'h00, 8'(i));
        for (int i = 0; i < 252; i++) access(0, 1, 0, 0, 0, 8'h00, 8'h00);

        for (int i = 0; i < 1500; i++) begin
            int k = $urandom_range(0, 9);
            logic [7:0] a = 8'($urandom);
            logic [7:0] w = 8'($urandom);
            if (k == 0) fetch(16'($urandom), "R3 random fetch");
            else if (k == 1) access(1, 0, 0, 0, 0, a, w);
            else if (k == 2) access(0, 1, 0, 0, 0, a, w);
            else access(0, 0, 1, 1'($urandom), 1'($urandom), a, w);
        end

        @(negedge clk);
        clear_inputs();
        summary();
    end
endmodule